// File: doc/BRIEF.md
# Stack Pointer Push/Pop Address Unit

This block owns the 16-bit stack pointer of a small processor and sequences the memory traffic of stack saves and restores. A save request names one of the four general registers or the status byte. The unit first lowers the pointer by the operand size and then issues a write at the lowered address. A restore request reads at the current pointer. When memory answers, the unit returns the value on a writeback port and raises the pointer by the operand size. General registers travel as 16-bit words. The status register travels as a single byte.

Two further operations move the pointer to and from register R0. A load copies the presented R0 value into the pointer in one cycle. A read returns the pointer on the writeback port, addressed to R0. Only one memory operation is outstanding at any time. While it waits for the acknowledge, `busy` is high and new requests are ignored. The memory side stores a word little-endian, with the low byte at `mem_addr` and the high byte at `mem_addr + 1`.

The controller has five states:
- IDLE: accepts requests.
- PUSH_WR: holds the write until acknowledged, then returns to IDLE.
- POP_RD: holds the read until acknowledged, then goes to POP_RET.
- POP_RET: presents the restored value for one cycle, then returns to IDLE.
- SP_RET: presents the pointer for one cycle, then returns to IDLE.

From IDLE:
- A valid save goes to PUSH_WR.
- A valid restore goes to POP_RD.
- A pointer read goes to SP_RET.
- A pointer load, or a save or restore with an unknown register select, stays in IDLE.

Top module: `stack_addr_unit`

## Requirements
- R1: After reset, `sp_out` is 0x0000, `busy`, `mem_req` and `wb_valid` are low, and a pointer read returns 0x0000.
- R2: A save of R0..R3 (`op_code`=0, `reg_sel` 0..3) lowers the pointer by 2 on the accepting edge. It then requests a word write (`mem_we`=1, `mem_size`=1) at the lowered pointer, carrying `reg_data`.
- R3: A save of the status byte (`reg_sel`=4) lowers the pointer by 1. It then requests a byte write (`mem_size`=0) at the lowered pointer, with `mem_wdata` holding `reg_data[7:0]` and zeros above.
- R4: A restore of R0..R3 (`op_code`=1) requests a word read at the unchanged pointer. One cycle after the acknowledging edge, `wb_valid` is high with `wb_sel` equal to the register and `wb_data` equal to `mem_rdata`. The pointer is then 2 higher.
- R5: A restore of the status byte requests a byte read and raises the pointer by 1. Its `wb_data` is `mem_rdata[7:0]` with zeros above, whatever the upper read bits are.
- R6: Pointer arithmetic wraps modulo 2^16 in both directions.
- R7: While an operation is outstanding:
  - `busy` stays high.
  - `mem_req`, `mem_addr`, `mem_we` and `mem_size` hold until `mem_ack`.
  - Any request presented meanwhile is ignored.
- R8: A pointer load (`op_code`=2) sets `sp_out` to `reg_data` on the accepting edge, with no memory request and `busy` staying low.
- R9: A pointer read (`op_code`=3) gives, one cycle later, a single-cycle `wb_valid` with `wb_sel`=0 and `wb_data` equal to the pointer.
- R10: A save or restore with `reg_sel` 5..7 is ignored: no memory request, no busy, and no pointer change.
- R11: Saves followed by restores in reverse order return the saved values, forming a last-in first-out stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request strobe, taken when `busy` is low |
| op_code | input | 2 | 0 save, 1 restore, 2 load pointer from R0, 3 read pointer to R0 |
| reg_sel | input | 3 | 0..3 general registers, 4 status byte |
| reg_data | input | 16 | Register value for a save, or R0 for a load |
| busy | output | 1 | Operation outstanding |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Byte address |
| mem_size | output | 1 | 1 word, 0 byte |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory completes the request on this edge |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| wb_valid | output | 1 | Writeback strobe |
| wb_sel | output | 3 | Writeback destination register |
| wb_data | output | 16 | Writeback value |
| sp_out | output | 16 | Current stack pointer |

## Verification
The main sweep presents every register select, including the three unknown ones, at four memory latencies. The saves run in ascending order and the restores in descending order. This separates word and byte sizing, since the pointer steps differ. It exposes a pointer that moves at the wrong edge, because the address is compared before the acknowledge. It shows whether requests sent during the wait are truly ignored, because a stray pointer load is offered in every wait cycle. The read model returns junk in the upper byte for byte reads, which tells zero-extension apart from pass-through. A run straddling address 0x0000 tells modulo wraparound apart from saturation or a carry into a wider pointer.

// File: rtl/sau_pkg.sv
package sau_pkg;

    typedef enum logic [1:0] {
        OP_PUSH    = 2'd0,
        OP_POP     = 2'd1,
        OP_SP_LOAD = 2'd2,
        OP_SP_READ = 2'd3
    } sau_op_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_WR = 3'd1,
        ST_POP_RD  = 3'd2,
        ST_POP_RET = 3'd3,
        ST_SP_RET  = 3'd4
    } sau_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/sau_sel_decode.sv
module sau_sel_decode #(
    parameter int unsigned DW      = 16,
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned NUM_GPR = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [DW-1:0]    data,
    output logic             sel_ok,
    output logic             is_byte,
    output logic [DW-1:0]    wdata
);
    import sau_pkg::*;

    // the status byte sits directly above the last general register
    localparam logic [SEL_W-1:0] STATUS_SEL = SEL_W'(NUM_GPR);

    always_comb begin
        is_byte = (sel == STATUS_SEL);
        sel_ok  = (sel <= STATUS_SEL);
    end

    generate
        if (DW > BYTE_W) begin : g_zext
            assign wdata = is_byte ? {{(DW-BYTE_W){1'b0}}, data[BYTE_W-1:0]} : data;
        end else begin : g_pass
            assign wdata = data;
        end
    endgenerate

endmodule

// File: rtl/sau_step.sv
module sau_step #(
    parameter int unsigned AW     = 16,
    parameter int unsigned DW     = 16,
    parameter bit          DIR_UP = 1'b0
) (
    input  logic [AW-1:0] base,
    input  logic          is_byte,
    output logic [AW-1:0] result
);
    localparam int unsigned WORD_BYTES = DW / 8;

    logic [AW-1:0] step;

    always_comb begin
        step = is_byte ? AW'(1) : AW'(WORD_BYTES);
    end

    generate
        if (DIR_UP) begin : g_inc
            assign result = base + step;
        end else begin : g_dec
            assign result = base - step;
        end
    endgenerate

endmodule

// File: rtl/sau_sp_reg.sv
module sau_sp_reg #(
    parameter int unsigned      AW       = 16,
    parameter logic [AW-1:0]    RESET_SP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_val,
    output logic [AW-1:0] sp_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= RESET_SP;
        end else if (ld_en) begin
            sp_q <= ld_val;
        end
    end

endmodule

// File: rtl/sau_ctrl.sv
module sau_ctrl #(
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 16,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [DW-1:0]    reg_data,
    input  logic             sel_ok,
    input  logic             sel_byte,
    input  logic [DW-1:0]    sel_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [AW-1:0]    sp_q,
    input  logic [AW-1:0]    sp_dec,
    input  logic [AW-1:0]    sp_inc,
    output logic             sp_ld_en,
    output logic [AW-1:0]    sp_ld_val,
    output logic             cur_byte,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_size,
    output logic [DW-1:0]    mem_wdata,
    output logic             wb_valid,
    output logic [SEL_W-1:0] wb_sel,
    output logic [DW-1:0]    wb_data
);
    import sau_pkg::*;

    sau_state_e       state_q, state_d;
    logic             accept;
    logic [SEL_W-1:0] cur_sel;
    logic [DW-1:0]    cur_wdata;
    logic [DW-1:0]    ret_data;
    logic [DW-1:0]    rd_fmt;

    assign accept = op_valid && (state_q == ST_IDLE);

    generate
        if (DW > BYTE_W) begin : g_rd_zext
            assign rd_fmt = cur_byte ? {{(DW-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]} : mem_rdata;
        end else begin : g_rd_pass
            assign rd_fmt = mem_rdata;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and pointer update
    always_comb begin
        state_d   = state_q;
        sp_ld_en  = 1'b0;
        sp_ld_val = sp_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    unique case (sau_op_e'(op_code))
                        OP_PUSH: begin
                            if (sel_ok) begin
                                state_d   = ST_PUSH_WR;
                                sp_ld_en  = 1'b1;
                                sp_ld_val = sp_dec;
                            end
                        end
                        OP_POP: begin
                            if (sel_ok) begin
                                state_d = ST_POP_RD;
                            end
                        end
                        OP_SP_LOAD: begin
                            sp_ld_en  = 1'b1;
                            sp_ld_val = AW'(reg_data);
                        end
                        OP_SP_READ: begin
                            state_d = ST_SP_RET;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PUSH_WR: begin
                if (mem_ack) begin
                    state_d = ST_IDLE;
                end
            end
            ST_POP_RD: begin
                if (mem_ack) begin
                    state_d   = ST_POP_RET;
                    sp_ld_en  = 1'b1;
                    sp_ld_val = sp_inc;
                end
            end
            ST_POP_RET: state_d = ST_IDLE;
            ST_SP_RET:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // request capture and return data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_sel   <= '0;
            cur_byte  <= 1'b0;
            cur_wdata <= '0;
            ret_data  <= '0;
        end else begin
            if (accept) begin
                cur_sel   <= reg_sel;
                cur_byte  <= sel_byte;
                cur_wdata <= sel_wdata;
                if (sau_op_e'(op_code) == OP_SP_READ) begin
                    cur_sel  <= '0;
                    ret_data <= DW'(sp_q);
                end
            end
            if ((state_q == ST_POP_RD) && mem_ack) begin
                ret_data <= rd_fmt;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_req   = (state_q == ST_PUSH_WR) || (state_q == ST_POP_RD);
        mem_we    = (state_q == ST_PUSH_WR);
        mem_addr  = mem_req ? sp_q : '0;
        mem_size  = mem_req && !cur_byte;
        mem_wdata = mem_we ? cur_wdata : '0;
        wb_valid  = (state_q == ST_POP_RET) || (state_q == ST_SP_RET);
        wb_sel    = wb_valid ? cur_sel : '0;
        wb_data   = wb_valid ? ret_data : '0;
    end

endmodule

// File: rtl/stack_addr_unit.sv
module stack_addr_unit #(
    parameter int unsigned   AW       = 16,
    parameter int unsigned   DW       = 16,
    parameter int unsigned   SEL_W    = 3,
    parameter int unsigned   NUM_GPR  = 4,
    parameter logic [AW-1:0] RESET_SP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [DW-1:0]    reg_data,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_size,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             wb_valid,
    output logic [SEL_W-1:0] wb_sel,
    output logic [DW-1:0]    wb_data,
    output logic [AW-1:0]    sp_out
);

    logic          sel_ok, sel_byte, cur_byte, sp_ld_en;
    logic [DW-1:0] sel_wdata;
    logic [AW-1:0] sp_q, sp_dec, sp_inc, sp_ld_val;

    sau_sel_decode #(.DW(DW), .SEL_W(SEL_W), .NUM_GPR(NUM_GPR)) u_dec (
        .sel     (reg_sel),
        .data    (reg_data),
        .sel_ok  (sel_ok),
        .is_byte (sel_byte),
        .wdata   (sel_wdata)
    );

    sau_step #(.AW(AW), .DW(DW), .DIR_UP(1'b0)) u_predec (
        .base    (sp_q),
        .is_byte (sel_byte),
        .result  (sp_dec)
    );

    sau_step #(.AW(AW), .DW(DW), .DIR_UP(1'b1)) u_postinc (
        .base    (sp_q),
        .is_byte (cur_byte),
        .result  (sp_inc)
    );

    sau_sp_reg #(.AW(AW), .RESET_SP(RESET_SP)) u_sp (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (sp_ld_en),
        .ld_val (sp_ld_val),
        .sp_q   (sp_q)
    );

    sau_ctrl #(.AW(AW), .DW(DW), .SEL_W(SEL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .reg_sel   (reg_sel),
        .reg_data  (reg_data),
        .sel_ok    (sel_ok),
        .sel_byte  (sel_byte),
        .sel_wdata (sel_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .sp_q      (sp_q),
        .sp_dec    (sp_dec),
        .sp_inc    (sp_inc),
        .sp_ld_en  (sp_ld_en),
        .sp_ld_val (sp_ld_val),
        .cur_byte  (cur_byte),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .wb_valid  (wb_valid),
        .wb_sel    (wb_sel),
        .wb_data   (wb_data)
    );

    assign sp_out = sp_q;

endmodule

// File: rtl/sau_chk.sv
module sau_chk #(
    parameter int unsigned AW      = 16,
    parameter int unsigned DW      = 16,
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned NUM_GPR = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [1:0]       op_code,
    input logic [SEL_W-1:0] reg_sel,
    input logic [DW-1:0]    reg_data,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_size,
    input logic [DW-1:0]    mem_wdata,
    input logic             mem_ack,
    input logic [DW-1:0]    mem_rdata,
    input logic             wb_valid,
    input logic [SEL_W-1:0] wb_sel,
    input logic [DW-1:0]    wb_data,
    input logic [AW-1:0]    sp_out
);
    localparam logic [SEL_W-1:0] ST_SEL = SEL_W'(NUM_GPR);

    logic idle_req;
    assign idle_req = op_valid && !busy;

    assert_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

    assert_push_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && op_code == 2'd0 && reg_sel < ST_SEL)
        |=> (sp_out == $past(sp_out) - AW'(2) && mem_req && mem_we && mem_size && mem_addr == sp_out));

    assert_push_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && op_code == 2'd0 && reg_sel == ST_SEL)
        |=> (sp_out == $past(sp_out) - AW'(1) && mem_req && mem_we && !mem_size && mem_addr == sp_out));

    assert_pop_postinc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we)
        |=> (wb_valid && sp_out == $past(sp_out) + ($past(mem_size) ? AW'(2) : AW'(1))));

    assert_sp_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && op_code == 2'd2) |=> (sp_out == AW'($past(reg_data)) && !busy && !mem_req));

    assert_bad_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && op_code[1] == 1'b0 && reg_sel > ST_SEL) |=> (!busy && $stable(sp_out)));

    assert_wb_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

endmodule

bind stack_addr_unit sau_chk #(.AW(AW), .DW(DW), .SEL_W(SEL_W), .NUM_GPR(NUM_GPR)) u_chk (.*);

// File: tb/tb_stack_addr_unit.sv
module tb_stack_addr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_data = '0;
    logic        busy, mem_req, mem_we, mem_size, wb_valid;
    logic [15:0] mem_addr, mem_wdata, wb_data, sp_out;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [2:0]  wb_sel;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_sp;
    logic [7:0]  bmem [0:255];
    logic [15:0] pv [0:4];

    always #5 clk = ~clk;

    stack_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .reg_sel(reg_sel), .reg_data(reg_data), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_data(wb_data), .sp_out(sp_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_phase(input string tag, input int lat);
        for (int w = 0; w < lat; w++) begin
            op_valid = 1'b1; op_code = 2'd2; reg_data = 16'hDEAD;
            @(negedge clk);
            chk({tag, " R7 hold req"}, {15'd0, mem_req}, 32'd1);
            chk({tag, " R7 hold addr"}, {16'd0, mem_addr}, {16'd0, exp_sp});
            chk({tag, " R7 busy"}, {31'd0, busy}, 32'd1);
        end
        op_valid = 1'b0;
    endtask

    task automatic do_push(input int sel, input logic [15:0] val, input int lat);
        logic [15:0] step;
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd0; reg_sel = 3'(sel); reg_data = val;
        @(negedge clk);
        op_valid = 1'b0;
        if (sel > 4) begin
            chk("R10 push bad sel busy", {31'd0, busy}, 32'd0);
            chk("R10 push bad sel sp", {16'd0, sp_out}, {16'd0, exp_sp});
            return;
        end
        step = (sel == 4) ? 16'd1 : 16'd2;
        exp_sp = exp_sp - step;
        if (sel == 4) begin
            chk("R3 byte push addr", {16'd0, mem_addr}, {16'd0, exp_sp});
            chk("R3 byte push ctl", {29'd0, mem_req, mem_we, mem_size}, 32'b110);
            chk("R3 byte push data", {16'd0, mem_wdata}, {24'd0, val[7:0]});
        end else begin
            chk("R2 word push addr", {16'd0, mem_addr}, {16'd0, exp_sp});
            chk("R2 word push ctl", {29'd0, mem_req, mem_we, mem_size}, 32'b111);
            chk("R2 word push data", {16'd0, mem_wdata}, {16'd0, val});
        end
        wait_phase("push", lat);
        mem_ack = 1'b1;
        bmem[mem_addr[7:0]] = mem_wdata[7:0];
        if (mem_size) bmem[8'(mem_addr[7:0] + 8'd1)] = mem_wdata[15:8];
        @(negedge clk);
        mem_ack = 1'b0;
        chk("R7 push done busy", {31'd0, busy}, 32'd0);
        chk("R7 push sp after stray load", {16'd0, sp_out}, {16'd0, exp_sp});
    endtask

    task automatic do_pop(input int sel, input logic [15:0] exp, input int lat);
        logic [15:0] step;
        logic [7:0]  a;
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd1; reg_sel = 3'(sel);
        @(negedge clk);
        op_valid = 1'b0;
        if (sel > 4) begin
            chk("R10 pop bad sel busy", {31'd0, busy}, 32'd0);
            chk("R10 pop bad sel req", {31'd0, mem_req}, 32'd0);
            chk("R10 pop bad sel sp", {16'd0, sp_out}, {16'd0, exp_sp});
            return;
        end
        step = (sel == 4) ? 16'd1 : 16'd2;
        chk("R4 pop addr", {16'd0, mem_addr}, {16'd0, exp_sp});
        chk("R4 pop ctl", {29'd0, mem_req, mem_we, mem_size}, {29'd0, 1'b1, 1'b0, sel != 4});
        wait_phase("pop", lat);
        a = mem_addr[7:0];
        mem_rdata = mem_size ? {bmem[8'(a + 8'd1)], bmem[a]} : {8'hA5, bmem[a]};
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        exp_sp = exp_sp + step;
        chk(sel == 4 ? "R5 pop byte data" : "R11 pop word data", {16'd0, wb_data}, {16'd0, exp});
        chk("R4 pop wb", {28'd0, wb_valid, wb_sel}, {28'd1, 3'(sel)});
        chk(sel == 4 ? "R5 pop sp" : "R4 pop sp", {16'd0, sp_out}, {16'd0, exp_sp});
        @(negedge clk);
        chk("R9 pop wb one cycle", {30'd0, wb_valid, busy}, 32'd0);
    endtask

    task automatic do_load(input logic [15:0] val);
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd2; reg_data = val;
        @(negedge clk);
        op_valid = 1'b0;
        exp_sp = val;
        chk("R8 load sp", {16'd0, sp_out}, {16'd0, val});
        chk("R8 load idle", {30'd0, busy, mem_req}, 32'd0);
    endtask

    task automatic do_read(input string tag);
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd3;
        @(negedge clk);
        op_valid = 1'b0;
        chk({tag, " R9 read wb"}, {12'd0, wb_valid, wb_sel, wb_data}, {12'd0, 1'b1, 3'd0, exp_sp});
        @(negedge clk);
        chk({tag, " R9 read pulse"}, {31'd0, wb_valid}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
        exp_sp = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R1 reset sp", {16'd0, sp_out}, 32'd0);
        chk("R1 reset ctl", {29'd0, busy, mem_req, wb_valid}, 32'd0);
        rst_n = 1'b1;
        do_read("R1");

        for (int lat = 0; lat < 4; lat++) begin
            do_load(16'h0200 + 16'(lat) * 16'h0040);
            for (int s = 0; s < 8; s++) begin
                logic [15:0] v;
                v = 16'(s + 1) * 16'h1357 + 16'(lat) * 16'h0F0F + 16'h8000;
                if (s < 5) pv[s] = v;
                do_push(s, v, lat);
            end
            do_read("sweep");
            for (int s = 7; s >= 0; s--) begin
                logic [15:0] e;
                e = (s == 4) ? {8'h00, pv[4][7:0]} : ((s < 4) ? pv[s] : 16'h0000);
                do_pop(s, e, lat);
            end
            chk("R11 sp restored", {16'd0, sp_out}, {16'd0, 16'h0200 + 16'(lat) * 16'h0040});
        end

        do_load(16'h0001);
        do_push(2, 16'hBEEF, 1);
        chk("R6 wrap word push", {16'd0, sp_out}, 32'h0000FFFF);
        do_push(4, 16'h12C3, 0);
        chk("R6 wrap byte push", {16'd0, sp_out}, 32'h0000FFFE);
        do_read("R6");
        do_pop(4, 16'h00C3, 2);
        do_pop(2, 16'hBEEF, 0);
        chk("R6 wrap back", {16'd0, sp_out}, 32'h00000001);
        do_load(16'h0000);
        do_push(4, 16'hFF7E, 0);
        chk("R6 wrap status push", {16'd0, sp_out}, 32'h0000FFFF);
        do_pop(4, 16'h007E, 1);
        chk("R6 wrap status pop", {16'd0, sp_out}, 32'h00000000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule